// File: doc/BRIEF.md
# Sync-Gated Serial Bit Receive Buffer

This block collects demodulated receive bits, one per strobe from a recovered bit clock, into a 48-entry single-bit buffer. The bits are read back one at a time, oldest first. Filling does not begin until a start condition holds. The start source is chosen at run time from four options: follow a valid-data qualifier, hunt for the 16-bit pattern 0x2DD4 (two codes), or start at once. A host-facing threshold flag rises when the number of held bits reaches a programmable 6-bit level. The block also drives an empty flag and a sticky overflow flag.

Bits enter as a stream with `in_valid` and no ready. The radio cannot be stalled, so a bit offered while the buffer is full and no bit leaves in that cycle is dropped and recorded in `overflow`. Bits leave on a valid/ready handshake. `out_valid` is high whenever at least one bit is held, and `out_bit` then shows the oldest bit. A bit is consumed on a rising clock edge where both `out_valid` and `out_ready` are high. `out_ready` has no effect while `out_valid` is low.

Top module: `syncgate_bit_fifo`

## Requirements
- R1: Bits are read in arrival order. `out_bit` shows the oldest held bit while `out_valid` is high, and one bit is removed per clock edge with `out_valid` and `out_ready` both high.
- R2: With `start_sel` = 2'b11, every `in_valid` bit is stored while `fifo_en` and `fill_en` are high.
- R3: With `start_sel` = 2'b00, a bit is stored only if `vdi` is high in the same cycle as `in_valid`.
- R4: With `start_sel` = 2'b01 or 2'b10, nothing is stored until the last 16 received bits, oldest first, equal 16'h2DD4. The bit that completes the match is not stored. Every later bit is stored until `fill_en` falls.
- R5: `level_hit` is high exactly when the held-bit count is greater than or equal to `level`. With `level` = 1 it signals that data is available.
- R6: `empty` is high exactly when no bit is held, and `out_valid` equals its inverse.
- R7: A bit offered while 48 bits are held and no bit is read in the same cycle is dropped and sets `overflow`. `overflow` stays set until a cycle with `status_rd` high and no new drop.
- R8: While `fill_en` is low, incoming bits are ignored and held bits stay readable. In the first cycle after `fill_en` rises, the buffer is emptied and sync hunting restarts.
- R9: While `fifo_en` is low, the buffer is emptied and no bit is stored.
- R10: A write and a read in the same cycle leave the count unchanged, including when 48 bits are held (no overflow).
- R11: After reset the buffer is empty, `overflow` is low and no start condition is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bit | input | 1 | Received data bit |
| in_valid | input | 1 | One-cycle strobe marking `in_bit` as a new bit |
| vdi | input | 1 | Valid-data qualifier |
| fifo_en | input | 1 | Buffer enable; low empties the buffer |
| fill_en | input | 1 | Fill enable; a rising edge flushes and re-arms |
| start_sel | input | 2 | Start source: 00 qualifier, 01/10 sync word, 11 immediate |
| level | input | 6 | Threshold bit count |
| status_rd | input | 1 | Status read pulse; clears `overflow` |
| out_ready | input | 1 | Consumer accepts `out_bit` |
| out_valid | output | 1 | A bit is available on `out_bit` |
| out_bit | output | 1 | Oldest held bit |
| level_hit | output | 1 | Held count is at or above `level` |
| empty | output | 1 | No bit is held |
| overflow | output | 1 | Sticky: a bit was dropped because the buffer was full |

## Verification
The collision that matters is a bit arriving in the same cycle as a read. It is provoked twice. The first time is inside the vector table on a partly filled buffer and on an empty one; on the empty one the read must be ignored and the write accepted. The second time is with all 48 bits held. There the combined operation must leave `overflow` low and must put the new bit at the tail, and reading out all 48 bits afterwards shows whether it did. A lone extra write then sets `overflow`.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int SYNC_W = 16;
  localparam logic [SYNC_W-1:0] SYNC_WORD = 16'h2DD4;

  typedef enum logic [1:0] {
    START_VDI    = 2'b00,
    START_SYNC_A = 2'b01,
    START_SYNC_B = 2'b10,
    START_NOW    = 2'b11
  } start_e;
endpackage

// File: rtl/sbf_sync_hunt.sv
module sbf_sync_hunt
  import sbf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic shift_en,
  input  logic bit_in,
  output logic hit
);
  localparam int SEEN_W = $clog2(SYNC_W + 1);

  logic [SYNC_W-1:0] shreg;
  logic [SEEN_W-1:0] seen;
  logic [SYNC_W-1:0] nxt;

  assign nxt = {shreg[SYNC_W-2:0], bit_in};
  // a match needs a full window of real bits, not reset zeros
  assign hit = shift_en && (seen >= SEEN_W'(SYNC_W - 1)) && (nxt == SYNC_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      seen  <= '0;
    end else if (clear) begin
      shreg <= '0;
      seen  <= '0;
    end else if (shift_en) begin
      shreg <= nxt;
      if (seen != SEEN_W'(SYNC_W)) seen <= seen + 1'b1;
    end
  end
endmodule

// File: rtl/sbf_fill_gate.sv
module sbf_fill_gate
  import sbf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fifo_en,
  input  logic   fill_en,
  input  start_e sel,
  input  logic   vdi,
  input  logic   in_valid,
  input  logic   sync_hit,
  output logic   flush,
  output logic   hunt_clear,
  output logic   shift_en,
  output logic   wr_req
);
  logic fill_q;
  logic armed;
  logic active;
  logic go;

  assign flush      = fifo_en & fill_en & ~fill_q;
  assign active     = fifo_en & fill_en & ~flush;
  assign hunt_clear = ~active;
  assign shift_en   = in_valid & active;

  always_comb begin
    case (sel)
      START_VDI:    go = vdi;
      START_SYNC_A,
      START_SYNC_B: go = armed;
      default:      go = 1'b1;
    endcase
  end

  assign wr_req = shift_en & go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      fill_q <= fill_en;
      if (!active)       armed <= 1'b0;
      else if (sync_hit) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/sbf_bit_ring.sv
module sbf_bit_ring #(
  parameter int DEPTH = 48,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_req,
  input  logic          wr_bit,
  input  logic          rd_req,
  input  logic          status_rd,
  output logic          rd_bit,
  output logic [CW-1:0] count,
  output logic          overflow
);
  localparam int PW = $clog2(DEPTH);

  logic [DEPTH-1:0] mem;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic full, pop, push, drop;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = (count == CW'(DEPTH));
  assign pop  = rd_req & (count != '0);
  assign push = wr_req & (~full | pop);
  assign drop = wr_req & full & ~pop;

  assign rd_bit = mem[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[i] <= 1'b0;
      else if (push && wr_ptr == PW'(i))     mem[i] <= wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step_ptr(wr_ptr);
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (drop)      overflow <= 1'b1;
    else if (status_rd) overflow <= 1'b0;
  end
endmodule

// File: rtl/syncgate_bit_fifo.sv
module syncgate_bit_fifo
  import sbf_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_bit,
  input  logic             in_valid,
  input  logic             vdi,
  input  logic             fifo_en,
  input  logic             fill_en,
  input  logic [1:0]       start_sel,
  input  logic [LVL_W-1:0] level,
  input  logic             status_rd,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic             level_hit,
  output logic             empty,
  output logic             overflow
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int XW = CW + LVL_W;

  logic flush, hunt_clear, shift_en, wr_req, sync_hit;
  logic [CW-1:0] count;

  sbf_sync_hunt u_hunt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (hunt_clear),
    .shift_en (shift_en),
    .bit_in   (in_bit),
    .hit      (sync_hit)
  );

  sbf_fill_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .fill_en    (fill_en),
    .sel        (start_e'(start_sel)),
    .vdi        (vdi),
    .in_valid   (in_valid),
    .sync_hit   (sync_hit),
    .flush      (flush),
    .hunt_clear (hunt_clear),
    .shift_en   (shift_en),
    .wr_req     (wr_req)
  );

  sbf_bit_ring #(.DEPTH(DEPTH), .CW(CW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush | ~fifo_en),
    .wr_req    (wr_req),
    .wr_bit    (in_bit),
    .rd_req    (out_ready),
    .status_rd (status_rd),
    .rd_bit    (out_bit),
    .count     (count),
    .overflow  (overflow)
  );

  assign empty     = (count == '0);
  assign out_valid = ~empty;
  assign level_hit = (XW'(count) >= XW'(level));
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             fifo_en,
  input logic             fill_en,
  input logic [LVL_W-1:0] level,
  input logic             status_rd,
  input logic             out_ready,
  input logic             out_valid,
  input logic             level_hit,
  input logic             empty,
  input logic             overflow
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !status_rd) |=> overflow); // R7

  AST_OVF_RISE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(in_valid)); // R7

  AST_IDLE_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_valid) |=> empty); // R6

  AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> empty); // R9

  AST_FILL_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !fill_en && !out_ready) |=> $stable(empty)); // R8

  AST_VALID_MATCHES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid != empty); // R6

  AST_EMPTY_BELOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && level != '0) |-> !level_hit); // R5
endmodule

bind syncgate_bit_fifo sbf_checker #(.LVL_W(LVL_W)) u_sbf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .fifo_en   (fifo_en),
  .fill_en   (fill_en),
  .level     (level),
  .status_rd (status_rd),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .level_hit (level_hit),
  .empty     (empty),
  .overflow  (overflow)
);

// File: tb/tb_syncgate_bit_fifo.sv
module tb_syncgate_bit_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_bit = 1'b0, in_valid = 1'b0, vdi = 1'b0;
  logic fifo_en = 1'b0, fill_en = 1'b0;
  logic [1:0] start_sel = 2'b11;
  logic [5:0] level = 6'd3;
  logic status_rd = 1'b0, out_ready = 1'b0;
  logic out_valid, out_bit, level_hit, empty, overflow;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  syncgate_bit_fifo dut (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid), .vdi(vdi),
    .fifo_en(fifo_en), .fill_en(fill_en), .start_sel(start_sel), .level(level),
    .status_rd(status_rd), .out_ready(out_ready), .out_valid(out_valid),
    .out_bit(out_bit), .level_hit(level_hit), .empty(empty), .overflow(overflow)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then sample after the edge
  task automatic cyc(input logic v, input logic b, input logic r);
    @(negedge clk);
    in_valid = v; in_bit = b; out_ready = r;
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic push(input logic b);
    cyc(1'b1, b, 1'b0);
  endtask

  task automatic pop(output logic b);
    @(negedge clk);
    out_ready = 1'b1;
    #1 b = out_bit;
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  task automatic set_fill(input logic f);
    @(negedge clk);
    fill_en = f;
  endtask

  // {in_valid, in_bit, out_ready, exp_empty, exp_level_hit, exp_out_bit}, level 3
  localparam logic [5:0] VEC [10] = '{
    6'b110_001, 6'b100_001, 6'b110_011, 6'b111_010, 6'b001_001,
    6'b001_001, 6'b101_000, 6'b001_100, 6'b001_100, 6'b111_001
  };

  localparam logic [15:0] SYNC = 16'h2DD4;

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic b;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(empty, 1'b1, "R11 empty at reset");
    chk(overflow, 1'b0, "R11 overflow at reset");
    chk(out_valid, 1'b0, "R6 out_valid at reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); fifo_en = 1'b1; fill_en = 1'b1; start_sel = 2'b11;
    @(posedge clk); #1;

    // vector walk: R1 R2 R5 R6 R10
    for (int i = 0; i < 10; i++) begin
      cyc(VEC[i][5], VEC[i][4], VEC[i][3]);
      chk(empty, VEC[i][2], $sformatf("R6 vec%0d empty", i));
      chk(level_hit, VEC[i][1], $sformatf("R5 vec%0d level_hit", i));
      if (!VEC[i][2]) chk(out_bit, VEC[i][0], $sformatf("R1 R10 vec%0d out_bit", i));
    end
    pop(b);
    chk(empty, 1'b1, "R1 drained");

    // level 1 as data-available
    level = 6'd1;
    push(1'b0);
    chk(level_hit, 1'b1, "R5 level one");
    pop(b);
    chk(level_hit, 1'b0, "R5 level one after drain");
    level = 6'd3;

    // R3 qualifier gating
    @(negedge clk); start_sel = 2'b00; vdi = 1'b0;
    for (int i = 0; i < 4; i++) push(1'b1);
    chk(empty, 1'b1, "R3 vdi low ignored");
    @(negedge clk); vdi = 1'b1;
    push(1'b1); push(1'b0);
    pop(b); chk(b, 1'b1, "R3 first bit");
    pop(b); chk(b, 1'b0, "R3 second bit");
    chk(empty, 1'b1, "R3 drained");

    // R4 sync hunt
    set_fill(1'b0);
    @(negedge clk); start_sel = 2'b01; fill_en = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) push(1'b0);
    chk(empty, 1'b1, "R4 before sync");
    for (int i = 15; i >= 0; i--) push(SYNC[i]);
    chk(empty, 1'b1, "R4 match bit not stored");
    push(1'b1); push(1'b1); push(1'b0);
    chk(level_hit, 1'b1, "R4 payload stored");
    // R8: fill off keeps contents, ignores input
    set_fill(1'b0);
    for (int i = 0; i < 4; i++) push(1'b1);
    pop(b); chk(b, 1'b1, "R8 kept bit0");
    pop(b); chk(b, 1'b1, "R8 kept bit1");
    pop(b); chk(b, 1'b0, "R8 kept bit2");
    chk(empty, 1'b1, "R8 no bits while fill off");
    set_fill(1'b1);
    for (int i = 0; i < 6; i++) push(1'b1);
    chk(empty, 1'b1, "R8 R4 re-armed hunt");

    // R8 rising fill_en flushes
    @(negedge clk); start_sel = 2'b10;
    for (int i = 15; i >= 0; i--) push(SYNC[i]);
    push(1'b1); push(1'b0);
    chk(empty, 1'b0, "R4 second sync code");
    set_fill(1'b0);
    set_fill(1'b1);
    @(posedge clk); #1;
    chk(empty, 1'b1, "R8 flush on fill rise");

    // R9 disable
    @(negedge clk); start_sel = 2'b11;
    push(1'b1); push(1'b1);
    @(negedge clk); fifo_en = 1'b0;
    push(1'b1);
    chk(empty, 1'b1, "R9 disabled empties");
    @(negedge clk); fifo_en = 1'b1;
    @(posedge clk); #1;
    chk(empty, 1'b1, "R9 still empty after enable");

    // R7 R10 full buffer
    @(negedge clk); level = 6'd48;
    for (int i = 0; i < 48; i++) push((i % 3) == 0);
    chk(level_hit, 1'b1, "R5 full level");
    chk(overflow, 1'b0, "R7 no overflow at 48");
    cyc(1'b1, 1'b0, 1'b1);
    chk(overflow, 1'b0, "R10 write+read when full");
    chk(level_hit, 1'b1, "R10 count kept at 48");
    push(1'b1);
    chk(overflow, 1'b1, "R7 overflow set");
    for (int i = 1; i < 48; i++) begin
      pop(b);
      chk(b, (i % 3) == 0, $sformatf("R1 R7 readout %0d", i));
    end
    pop(b);
    chk(b, 1'b0, "R10 tail bit");
    chk(empty, 1'b1, "R7 dropped bit absent");
    chk(overflow, 1'b1, "R7 sticky");
    @(negedge clk); status_rd = 1'b1;
    @(posedge clk); #1;
    status_rd = 1'b0;
    chk(overflow, 1'b0, "R7 cleared by status read");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule